// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This block sits in a transmit path and takes frames that carry an 8-byte control prefix ahead of the packet. The prefix selects checksum work on an IPv4 packet. Byte 0 holds the request flags. Byte 2 gives the distance from the IPv4 header to the TCP/UDP header. Byte 3 gives the distance from the end of the prefix to the IPv4 header. The block stores the whole frame in a local byte store. It works out the IPv4 header checksum, the TCP or UDP checksum, or a zeroed UDP checksum, as the flags request, and writes each result into the stored frame. It then streams the frame out with the prefix removed.

Flag bits of prefix byte 0: bit 7 marks an IPv4 packet, bit 5 marks a TCP/UDP header, bit 4 selects UDP (clear means TCP), bit 3 requests the IPv4 header checksum and bit 2 requests the TCP/UDP checksum. Bit 6 and bits 1..0 have no effect. All checksums are 16-bit one's-complement sums with end-around carry, taken with the checksum field counted as zero and stored most significant byte first. The TCP/UDP sum also covers a pseudo-header made of the source and destination addresses, the protocol byte and the L4 length.

The top controller is a state machine with these states:
- S_LOAD accepts bytes.
- S_IP_SUM walks the IPv4 header.
- S_PH_SUM walks the two addresses and adds the protocol and length.
- S_L4_SUM walks the TCP/UDP span.
- S_PATCH_HI and S_PATCH_LO write the two result bytes.
- S_SEND streams the frame out.

The transitions are these:
- S_LOAD goes to S_IP_SUM, S_PH_SUM, S_PATCH_HI or S_SEND on the last input byte. It stays in S_LOAD for a frame of 8 bytes or fewer.
- Each sum state leaves when its span is done. S_IP_SUM goes to S_PATCH_HI, S_PH_SUM goes to S_L4_SUM, and S_L4_SUM goes to S_PATCH_HI.
- S_PATCH_HI goes to S_PATCH_LO.
- S_PATCH_LO goes to the L4 route (S_PH_SUM, S_PATCH_HI or S_SEND) after an IPv4 patch, and to S_SEND otherwise.
- S_SEND goes back to S_LOAD when the last byte is taken.

Top module: `tx_csum_offload`

## Requirements
- R1: The output frame is the input frame with its first 8 bytes removed. It has input length minus 8 bytes, and out_last marks its final byte. After that byte is taken, in_ready returns high.
- R2: When flag bits 7 and 3 are both set, the IPv4 header checksum is computed and written at IPv4 header bytes 10..11. The header length comes from the low nibble of its first byte times 4. The other flag bits, including bit 6, do not affect this.
- R3: When flag bits 7, 5, 4 and 2 are all set, the UDP checksum is computed with the pseudo-header and written at L4 header bytes 6..7.
- R4: When flag bits 7, 5 and 4 are set and bit 2 is clear, L4 header bytes 6..7 are sent as zero and nothing else changes.
- R5: When flag bits 7, 5 and 2 are set and bit 4 is clear, the TCP checksum is computed with the pseudo-header and written at L4 header bytes 16..17.
- R6: When flag bits 7 and 5 are set and bits 4 and 2 are clear, the TCP header passes through unchanged.
- R7: When flag bit 7 is clear, the frame passes through unchanged apart from prefix removal, whatever the other flag bits are.
- R8: A computed UDP checksum of 0x0000 is sent as 0xFFFF.
- R9: in_ready and out_valid are never high together. While out_valid is high and out_ready low, out_data and out_last hold.
- R10: After reset, in_ready is high and out_valid is low.
- R11: The L4 length is the IPv4 total length minus the L4 offset. Bytes after that span are passed through but are not summed.
- R12: A frame of 8 bytes or fewer produces no output, and the block stays ready for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Input frame byte |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Input byte ends the frame |
| in_ready | output | 1 | Block accepts an input byte |
| out_data | output | 8 | Output frame byte |
| out_valid | output | 1 | Output byte present |
| out_last | output | 1 | Output byte ends the frame |
| out_ready | input | 1 | Sink accepts the output byte |

## Verification
The bench targets flag combinations that sit next to each other:
- UDP with and without the L4 request. A design that confuses them would compute a checksum where zeros are due, or zero a field it should fill.
- The IPv4 flag cleared while every other request bit is set. This exposes a design that gates work on the wrong bit.
- A TCP span of odd length. This catches a design that drops the final byte or places it in the low lane.

A UDP payload is tuned so that the sum comes out as zero, which shows whether the 0xFFFF substitution is present. Trailing bytes beyond the IPv4 total length would corrupt the checksum of a design that sums up to the end of the frame. A zero-length header offset and frames of 8 bytes or fewer cover the address edges and the empty-output case. Output stalls check that a stalled byte is neither skipped nor repeated.

// File: rtl/tco_pkg.sv
package tco_pkg;

    localparam int FCB_BYTES = 8;

    localparam int BIT_IP  = 7;
    localparam int BIT_L4  = 5;
    localparam int BIT_UDP = 4;
    localparam int BIT_CIP = 3;
    localparam int BIT_CL4 = 2;

    typedef enum logic [2:0] {
        S_LOAD,
        S_IP_SUM,
        S_PH_SUM,
        S_L4_SUM,
        S_PATCH_HI,
        S_PATCH_LO,
        S_SEND
    } tco_state_t;

    // two end-around folds reduce any 32-bit sum to 16 bits, then invert
    function automatic logic [15:0] fold_cpl(input logic [31:0] s);
        logic [16:0] a;
        logic [16:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = {1'b0, a[15:0]} + {16'b0, a[16]};
        return ~b[15:0];
    endfunction

endpackage

// File: rtl/tco_frame_buf.sv
module tco_frame_buf #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tco_csum_acc.sv
module tco_csum_acc #(
    parameter int ADD_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [ADD_W-1:0] addend,
    output logic [15:0]      result
);
    import tco_pkg::*;

    logic [31:0] acc_q;
    logic [31:0] acc_next;

    assign acc_next = acc_q + 32'(addend);
    // complemented fold including this cycle's addend
    assign result   = fold_cpl(acc_next);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clear)  acc_q <= '0;
        else if (add_en) acc_q <= acc_next;
    end

endmodule

// File: rtl/tx_csum_offload.sv
module tx_csum_offload #(
    parameter int DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready
);
    import tco_pkg::*;

    localparam int AW    = $clog2(DEPTH);
    localparam int ADD_W = 18;
    typedef logic [AW:0] ptr_t;

    tco_state_t state_q, state_d, l4_route;

    ptr_t          cnt_q, len_q, idx_q, stop_q;
    logic [AW-1:0] at_q;
    logic [7:0]    l3off_q, l4off_q, proto_q;
    logic [3:0]    ihl_q;
    logic [15:0]   tot_q, val_q;
    logic          f_ip, f_l4, f_udp, f_cip, f_cl4;
    logic          odd_q, post_ip_q;

    ptr_t        l3, l4, ip_end, l4_end, ck_at, ip_ck;
    logic [15:0] l4len, sum_res;
    logic        want_ip, want_l4, want_zero, accept, in_field;
    logic [7:0]  rd_byte, sum_byte, wd;
    logic [AW-1:0] wa;
    logic        we, add_en, clear;
    logic [ADD_W-1:0] addend;

    // ---------------- derived positions ----------------
    always_comb begin
        l3     = ptr_t'(FCB_BYTES) + ptr_t'(l3off_q);
        l4     = l3 + ptr_t'(l4off_q);
        ip_end = l3 + ptr_t'({ihl_q, 2'b00}) - ptr_t'(1);
        ip_ck  = l3 + ptr_t'(10);
        l4len  = tot_q - {8'h00, l4off_q};
        l4_end = l4 + ptr_t'(l4len) - ptr_t'(1);
        ck_at  = l4 + (f_udp ? ptr_t'(6) : ptr_t'(16));
        want_ip   = f_ip & f_cip;
        want_l4   = f_ip & f_l4 & f_cl4;
        want_zero = f_ip & f_l4 & f_udp & ~f_cl4;
        l4_route  = want_l4 ? S_PH_SUM : (want_zero ? S_PATCH_HI : S_SEND);
        accept    = in_valid && (state_q == S_LOAD);
    end

    // ---------------- summing lane ----------------
    always_comb begin
        in_field = ((state_q == S_IP_SUM) && (idx_q == ip_ck || idx_q == ip_ck + ptr_t'(1)))
                || ((state_q == S_L4_SUM) && (idx_q == ck_at || idx_q == ck_at + ptr_t'(1)));
        sum_byte = in_field ? 8'h00 : rd_byte;
        addend   = odd_q ? {10'b0, sum_byte} : {2'b0, sum_byte, 8'h00};
        if (state_q == S_PH_SUM && idx_q == stop_q)
            addend = addend + {10'b0, proto_q} + {2'b0, l4len};
        add_en = (state_q == S_IP_SUM) || (state_q == S_PH_SUM) || (state_q == S_L4_SUM);
        clear  = (state_q == S_LOAD) || (state_q == S_PATCH_LO);
    end

    tco_csum_acc #(.ADD_W(ADD_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .add_en (add_en),
        .addend (addend),
        .result (sum_res)
    );

    // ---------------- store write port ----------------
    always_comb begin
        we = 1'b0;
        wa = cnt_q[AW-1:0];
        wd = in_data;
        if (state_q == S_PATCH_HI) begin
            we = 1'b1; wa = at_q; wd = val_q[15:8];
        end else if (state_q == S_PATCH_LO) begin
            we = 1'b1; wa = at_q + AW'(1); wd = val_q[7:0];
        end else if (accept && cnt_q < ptr_t'(DEPTH)) begin
            we = 1'b1;
        end
    end

    tco_frame_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (wa),
        .wdata (wd),
        .raddr (idx_q[AW-1:0]),
        .rdata (rd_byte)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOAD:
                if (accept && in_last && cnt_q >= ptr_t'(FCB_BYTES))
                    state_d = want_ip ? S_IP_SUM : l4_route;
            S_IP_SUM:   if (idx_q == stop_q) state_d = S_PATCH_HI;
            S_PH_SUM:   if (idx_q == stop_q) state_d = S_L4_SUM;
            S_L4_SUM:   if (idx_q == stop_q) state_d = S_PATCH_HI;
            S_PATCH_HI: state_d = S_PATCH_LO;
            S_PATCH_LO: state_d = post_ip_q ? l4_route : S_SEND;
            S_SEND:     if (out_ready && idx_q == len_q - ptr_t'(1)) state_d = S_LOAD;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LOAD;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; len_q <= '0; idx_q <= '0; stop_q <= '0; at_q <= '0;
            l3off_q <= '0; l4off_q <= '0; proto_q <= '0; ihl_q <= '0;
            tot_q <= '0; val_q <= '0;
            f_ip <= 1'b0; f_l4 <= 1'b0; f_udp <= 1'b0; f_cip <= 1'b0; f_cl4 <= 1'b0;
            odd_q <= 1'b0; post_ip_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_LOAD: if (accept) begin
                    if (cnt_q == ptr_t'(0)) begin
                        f_ip  <= in_data[BIT_IP];  f_l4  <= in_data[BIT_L4];
                        f_udp <= in_data[BIT_UDP]; f_cip <= in_data[BIT_CIP];
                        f_cl4 <= in_data[BIT_CL4];
                    end
                    if (cnt_q == ptr_t'(2))            l4off_q      <= in_data;
                    if (cnt_q == ptr_t'(3))            l3off_q      <= in_data;
                    if (cnt_q == l3)                   ihl_q        <= in_data[3:0];
                    if (cnt_q == l3 + ptr_t'(2))       tot_q[15:8]  <= in_data;
                    if (cnt_q == l3 + ptr_t'(3))       tot_q[7:0]   <= in_data;
                    if (cnt_q == l3 + ptr_t'(9))       proto_q      <= in_data;
                    if (in_last) begin
                        len_q     <= cnt_q + ptr_t'(1);
                        cnt_q     <= '0;
                        post_ip_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + ptr_t'(1);
                    end
                end
                S_IP_SUM, S_PH_SUM, S_L4_SUM: begin
                    idx_q <= idx_q + ptr_t'(1);
                    odd_q <= ~odd_q;
                end
                S_SEND: if (out_ready) idx_q <= idx_q + ptr_t'(1);
                S_PATCH_HI, S_PATCH_LO: ;
            endcase

            if (state_d != state_q) begin
                unique case (state_d)
                    S_IP_SUM: begin
                        idx_q <= l3; stop_q <= ip_end; odd_q <= 1'b0; post_ip_q <= 1'b1;
                    end
                    S_PH_SUM: begin
                        idx_q <= l3 + ptr_t'(12); stop_q <= l3 + ptr_t'(19); odd_q <= 1'b0;
                    end
                    S_L4_SUM: begin
                        idx_q <= l4; stop_q <= l4_end; odd_q <= 1'b0;
                    end
                    S_PATCH_HI: begin
                        if (state_q == S_IP_SUM) begin
                            at_q  <= ip_ck[AW-1:0];
                            val_q <= sum_res;
                        end else begin
                            at_q      <= ck_at[AW-1:0];
                            post_ip_q <= 1'b0;
                            if (state_q == S_L4_SUM)
                                val_q <= (f_udp && sum_res == 16'h0000) ? 16'hFFFF : sum_res;
                            else
                                val_q <= 16'h0000;
                        end
                    end
                    S_SEND: idx_q <= ptr_t'(FCB_BYTES);
                    S_LOAD, S_PATCH_LO: ;
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = (state_q == S_LOAD);
        out_valid = (state_q == S_SEND);
        out_data  = rd_byte;
        out_last  = (state_q == S_SEND) && (idx_q == len_q - ptr_t'(1));
    end

endmodule

// File: rtl/tco_chk.sv
module tco_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_last,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);

    logic        fresh;
    logic [11:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh <= 1'b1;
            seen  <= '0;
        end else begin
            fresh <= 1'b0;
            if (in_valid && in_ready)
                seen <= in_last ? 12'd0 : ((seen == 12'hFFF) ? seen : seen + 12'd1);
        end
    end

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> (in_ready && !out_valid));

    assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_frame_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    assert_short_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && seen < 12'd8) |=> in_ready);

endmodule

bind tx_csum_offload tco_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tb_tx_csum_offload.sv
module tb_tx_csum_offload;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] l3off;
        logic [7:0] dlen;
        logic [3:0] pad;
        logic       tune;
        logic       bp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h88, 8'd14, 8'd10, 4'd0, 1'b0, 1'b0},
        '{8'hB4, 8'd14, 8'd12, 4'd0, 1'b0, 1'b0},
        '{8'hB0, 8'd14, 8'd9,  4'd0, 1'b0, 1'b1},
        '{8'hA4, 8'd14, 8'd11, 4'd0, 1'b0, 1'b0},
        '{8'hA0, 8'd14, 8'd10, 4'd0, 1'b0, 1'b0},
        '{8'h7C, 8'd14, 8'd10, 4'd0, 1'b0, 1'b0},
        '{8'hBC, 8'd14, 8'd12, 4'd3, 1'b0, 1'b1},
        '{8'hB4, 8'd14, 8'd12, 4'd0, 1'b1, 1'b0},
        '{8'hAC, 8'd0,  8'd7,  4'd0, 1'b0, 1'b1},
        '{8'h00, 8'd3,  8'd6,  4'd0, 1'b0, 1'b0},
        '{8'hC8, 8'd14, 8'd10, 4'd0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_ready = 1'b0;

    tx_csum_offload dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] fr  [256];
    logic [7:0] ex  [256];
    logic [7:0] got [256];
    int flen, elen, glen;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int fold16(input int s_in);
        int s = s_in;
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
        return s;
    endfunction

    function automatic int ones_sum(input int start, input int n);
        int s = 0;
        for (int i = 0; i < n; i++)
            s += (i % 2 == 0) ? (int'(ex[start+i]) << 8) : int'(ex[start+i]);
        return s;
    endfunction

    function automatic int l4_fold(input int l3, input int l4, input int l4len);
        return fold16(ones_sum(l3 + 12, 8) + int'(ex[l3+9]) + l4len + ones_sum(l4, l4len));
    endfunction

    function automatic string tag_of(input int v);
        case (v)
            0, 10:   return "R2";
            1:       return "R3";
            2:       return "R4";
            3, 8:    return "R5";
            4:       return "R6";
            5, 9:    return "R7";
            6:       return "R11";
            default: return "R8";
        endcase
    endfunction

    // expected output, computed from the requirements on a copy without the prefix
    task automatic compute_expected();
        int l3, l4, tot, l4len, pos, c;
        logic [7:0] f;
        f    = fr[0];
        elen = flen - 8;
        for (int j = 0; j < elen; j++) ex[j] = fr[j+8];
        l3 = int'(fr[3]);
        l4 = l3 + int'(fr[2]);
        tot = (int'(ex[l3+2]) << 8) | int'(ex[l3+3]);
        l4len = tot - int'(fr[2]);
        if (f[7] && f[3]) begin
            ex[l3+10] = 8'h00; ex[l3+11] = 8'h00;
            c = (~fold16(ones_sum(l3, 20))) & 32'hFFFF;
            ex[l3+10] = 8'(c >> 8); ex[l3+11] = 8'(c);
        end
        if (f[7] && f[5]) begin
            pos = f[4] ? l4 + 6 : l4 + 16;
            if (f[2]) begin
                ex[pos] = 8'h00; ex[pos+1] = 8'h00;
                c = (~l4_fold(l3, l4, l4len)) & 32'hFFFF;
                if (f[4] && c == 0) c = 32'hFFFF;
                ex[pos] = 8'(c >> 8); ex[pos+1] = 8'(c);
            end else if (f[4]) begin
                ex[pos] = 8'h00; ex[pos+1] = 8'h00;
            end
        end
    endtask

    task automatic build(input vec_t v);
        int b, l, hl, tot, dl, w;
        dl  = int'(v.dlen);
        b   = 8 + int'(v.l3off);
        hl  = v.flags[4] ? 8 : 20;
        tot = 20 + hl + dl;
        l   = b + 20;
        flen = b + tot + int'(v.pad);
        fr[0] = v.flags; fr[1] = 8'h5A; fr[2] = 8'd20; fr[3] = v.l3off;
        for (int i = 4; i < 8; i++) fr[i] = 8'(8'hC0 + i);
        for (int i = 0; i < int'(v.l3off); i++) fr[8+i] = 8'(8'h60 + i);
        fr[b+0] = 8'h45; fr[b+1] = 8'h00; fr[b+2] = 8'(tot >> 8); fr[b+3] = 8'(tot);
        fr[b+4] = 8'h12; fr[b+5] = 8'h34; fr[b+6] = 8'h40; fr[b+7] = 8'h00;
        fr[b+8] = 8'h40; fr[b+9] = v.flags[4] ? 8'd17 : 8'd6;
        fr[b+10] = 8'hBE; fr[b+11] = 8'hEF;
        fr[b+12] = 8'hC0; fr[b+13] = 8'hA8; fr[b+14] = 8'h00; fr[b+15] = 8'h01;
        fr[b+16] = 8'h0A; fr[b+17] = 8'h00; fr[b+18] = 8'h00; fr[b+19] = 8'h07;
        if (v.flags[4]) begin
            fr[l+0] = 8'h04; fr[l+1] = 8'hD2; fr[l+2] = 8'h00; fr[l+3] = 8'h35;
            fr[l+4] = 8'((8 + dl) >> 8); fr[l+5] = 8'(8 + dl);
            fr[l+6] = 8'hAB; fr[l+7] = 8'hCD;
        end else begin
            for (int j = 0; j < 20; j++) fr[l+j] = 8'(j * 11 + 5);
        end
        for (int k = 0; k < dl; k++) fr[l+hl+k] = 8'(k * 7 + 3);
        for (int k = 0; k < int'(v.pad); k++) fr[b+tot+k] = 8'hEE;
        if (v.tune) begin
            // choose two data bytes so that the UDP one's-complement sum is all ones
            fr[l+8] = 8'h00; fr[l+9] = 8'h00;
            for (int j = 0; j < flen - 8; j++) ex[j] = fr[j+8];
            ex[l-8+6] = 8'h00; ex[l-8+7] = 8'h00;
            w = 32'hFFFF - l4_fold(b - 8, l - 8, tot - 20);
            fr[l+8] = 8'(w >> 8); fr[l+9] = 8'(w);
        end
    endtask

    task automatic send_frame();
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            in_data  = fr[i];
            in_valid = 1'b1;
            in_last  = (i == flen - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(input bit bp);
        bit done = 0;
        bit hold = 0;
        logic [7:0] held = 8'h00;
        int cyc = 0;
        glen = 0;
        while (!done && cyc < 4000) begin
            if (cyc > 0) @(negedge clk);
            if (hold) check(out_valid && out_data == held, "R9", "stalled byte held",
                            int'(out_data), int'(held));
            out_ready = bp ? (cyc % 3 != 2) : 1'b1;
            hold = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                got[glen] = out_data;
                glen++;
                if (out_last) done = 1;
            end
            cyc++;
        end
        check(done, "R1", "frame end seen", int'(done), 1);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        int bad_i;
        v = VECS[vi];
        build(v);
        compute_expected();
        send_frame();
        // in_valid was dropped at this negedge; the block now holds the frame
        check(!in_ready, "R9", "in_ready low while frame held", int'(in_ready), 0);
        collect(v.bp);
        check(glen == elen, "R1", $sformatf("vector %0d length", vi), glen, elen);
        bad_i = -1;
        for (int i = 0; i < elen && i < glen; i++)
            if (bad_i < 0 && got[i] !== ex[i]) bad_i = i;
        if (bad_i < 0)
            check(1'b1, tag_of(vi), "frame bytes", 0, 0);
        else
            check(1'b0, tag_of(vi), $sformatf("vector %0d byte %0d", vi, bad_i),
                  int'(got[bad_i]), int'(ex[bad_i]));
        if (v.tune) begin
            int p;
            p = int'(v.l3off) + 20 + 6;
            check({got[p], got[p+1]} == 16'hFFFF, "R8", "zero sum sent as FFFF",
                  int'({got[p], got[p+1]}), 32'hFFFF);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R10", "reset state",
              int'({in_ready, out_valid}), 2);

        for (int vi = 0; vi < NV; vi++) run_vec(vi);

        // R12: frame of 6 bytes gives nothing and leaves the block ready
        begin
            bit seen_out = 0;
            flen = 6;
            for (int i = 0; i < 6; i++) fr[i] = 8'(8'h90 + i);
            send_frame();
            out_ready = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (out_valid) seen_out = 1;
            end
            out_ready = 1'b0;
            check(!seen_out, "R12", "no output for short frame", int'(seen_out), 0);
            check(in_ready, "R12", "ready after short frame", int'(in_ready), 1);
        end
        // R12: exactly 8 bytes is still short
        begin
            bit seen_out = 0;
            flen = 8;
            for (int i = 0; i < 8; i++) fr[i] = 8'(8'hA0 + i);
            send_frame();
            out_ready = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (out_valid) seen_out = 1;
            end
            out_ready = 1'b0;
            check(!seen_out, "R12", "no output for 8-byte frame", int'(seen_out), 0);
        end
        // a normal frame still works after short ones
        run_vec(3);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule